// File: doc/BRIEF.md
# Stored Token Sequence Emitter

This block turns one trigger into a burst of packets on the token bus. The trigger carries a starting cell address and a token count. The block then reads the stored sequence from consecutive memory cells and drives the flits onto the bus, in stored order and with no change to any flit.

Each token consists of two 16-bit flits. The first flit is the command or destination tag. The second is the return routing or data. Every memory cell holds one flit, so token `i` of a sequence sits at cells `base+2i` and `base+2i+1`.

The memory read port has one cycle of latency. A small flit buffer lets the next cell be fetched while the current flit waits for bus ready, so a sequence streams at one flit per cycle when the bus does not stall. While a sequence is being emitted, `busy` is high and the trigger port refuses new requests.

Top module: `tok_replay`

## Requirements
- R1: While reset is held, `busy` and `bus_valid` and `mem_rd_en` are 0 and `trig_ready` is 1.
- R2: A trigger is taken only in a cycle where `trig_valid` and `trig_ready` are both 1. `trig_ready` is the inverse of `busy`. A trigger offered while busy has no effect: no extra flits appear, either during the current sequence or after it.
- R3: A taken trigger with count N causes exactly 2×N bus handshakes. After that the block returns to idle.
- R4: Flit k of a sequence (k counted from 0) equals the memory cell at `base+k`. Flits appear in increasing k.
- R5: Cell addresses wrap modulo 2^ADDR_W. For example, base 1022 with ADDR_W=10 reads cells 1022, 1023, 0 and 1.
- R6: `bus_last` is 0 on even k, which is the first flit of a token. It is 1 on odd k, which is the second flit of a token.
- R7: While `bus_valid` is 1 and `bus_ready` is 0, the next cycle keeps `bus_valid` at 1 and holds `bus_flit` and `bus_last` unchanged.
- R8: Read data is captured one cycle after `mem_rd_en`. No read is issued unless buffer space is guaranteed for its data, so the buffer never overflows or underflows.
- R9: With `bus_ready` held at 1, the first flit is valid in the third cycle after the accepting clock edge. The remaining flits follow one per cycle with no gap.
- R10: A trigger with count 0 is accepted, causes no memory read and no flit, and `busy` stays 0.
- R11: `busy` is 1 from the cycle after a nonzero-count trigger is accepted until the clock edge of the final flit's handshake. It is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_valid | input | 1 | Trigger request |
| trig_ready | output | 1 | Trigger can be accepted (idle) |
| trig_base | input | ADDR_W | First cell of the stored sequence |
| trig_count | input | CNT_W | Number of two-flit tokens to emit |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | ADDR_W | Memory read address |
| mem_rd_data | input | FLIT_W | Read data, valid one cycle after the strobe |
| bus_valid | output | 1 | Flit present on the bus |
| bus_ready | input | 1 | Bus accepts the flit |
| bus_flit | output | FLIT_W | Flit payload |
| bus_last | output | 1 | Flit is the second of its token |
| busy | output | 1 | Sequence in progress |

## Verification
The embedded properties check the following on every cycle:
- the bus hold rule under backpressure;
- the alternation of the last-flit marker;
- buffer overflow and underflow;
- the address stepping by one per read;
- the busy response to zero and nonzero counts.

Other properties depend on the stored sequence as a whole, so only the bench scenarios can show them. These are:
- the exact flit total per trigger;
- data order and wrap across the address space;
- the three-cycle first-flit latency;
- gapless streaming;
- the silent rejection of triggers offered while busy.

The bench reference model predicts every flit from the memory pattern and compares on each clock.

// File: rtl/tr_pkg.sv
package tr_pkg;
   // Selects how the read-issue decision accounts for a flit leaving this cycle
   typedef enum logic {
      ISSUE_REGISTERED = 1'b0,  // room judged from registered occupancy only
      ISSUE_LOOKAHEAD  = 1'b1   // a departing flit frees room in the same cycle
   } tr_issue_e;
endpackage

// File: rtl/tr_addr_seq.sv
module tr_addr_seq #(
   parameter int ADDR_W = 10,
   parameter int REM_W  = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] base,
   input  logic [REM_W-1:0]  total,
   input  logic              step,
   output logic [ADDR_W-1:0] addr,
   output logic              rem_zero,
   output logic              odd
);
   logic [REM_W-1:0] rem_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr  <= '0;
         rem_q <= '0;
         odd   <= 1'b0;
      end else if (load) begin
         addr  <= base;
         rem_q <= total;
         odd   <= 1'b0;
      end else if (step) begin
         addr  <= addr + 1'b1;
         rem_q <= rem_q - 1'b1;
         odd   <= ~odd;
      end
   end

   assign rem_zero = (rem_q == '0);

   // R3: never read past the requested flit total
   assert_no_excess_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> !rem_zero);
   // R4 / R5: each read advances the address by one, wrapping
   assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load) |=> addr == ADDR_W'($past(addr) + 1'b1));
endmodule

// File: rtl/tr_flit_fifo.sv
module tr_flit_fifo #(
   parameter int W     = 17,
   parameter int DEPTH = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [W-1:0]     wr_data,
   input  logic             rd_en,
   output logic [W-1:0]     rd_data,
   output logic             empty,
   output logic [$clog2(DEPTH+1)-1:0] occ
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int OCC_W = $clog2(DEPTH + 1);

   logic [W-1:0]     store [DEPTH];
   logic [PTR_W-1:0] wr_ptr, rd_ptr;

   function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
      return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         occ    <= '0;
      end else begin
         if (wr_en) wr_ptr <= bump(wr_ptr);
         if (rd_en) rd_ptr <= bump(rd_ptr);
         occ <= occ + OCC_W'(wr_en) - OCC_W'(rd_en);
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en) store[wr_ptr] <= wr_data;
   end

   assign rd_data = store[rd_ptr];
   assign empty   = (occ == '0);

   assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (occ < OCC_W'(DEPTH)) || rd_en);
   assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |-> !empty);
endmodule

// File: rtl/tok_replay.sv
module tok_replay
   import tr_pkg::*;
#(
   parameter int        FLIT_W     = 16,
   parameter int        ADDR_W     = 10,
   parameter int        CNT_W      = 8,
   parameter int        BUF_DEPTH  = 2,
   parameter tr_issue_e ISSUE_MODE = ISSUE_LOOKAHEAD
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig_valid,
   output logic              trig_ready,
   input  logic [ADDR_W-1:0] trig_base,
   input  logic [CNT_W-1:0]  trig_count,
   output logic              mem_rd_en,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic [FLIT_W-1:0] mem_rd_data,
   output logic              bus_valid,
   input  logic              bus_ready,
   output logic [FLIT_W-1:0] bus_flit,
   output logic              bus_last,
   output logic              busy
);
   localparam int REM_W = CNT_W + 1;
   localparam int OCC_W = $clog2(BUF_DEPTH + 1);
   localparam int ENT_W = FLIT_W + 1;

   generate
      if (BUF_DEPTH < 2) begin : g_bad_depth
         $error("tok_replay: BUF_DEPTH must be at least 2");
      end
      if (FLIT_W < 1 || ADDR_W < 1 || CNT_W < 1) begin : g_bad_width
         $error("tok_replay: widths must be positive");
      end
   endgenerate

   logic             load, issue, room, pop;
   logic             rem_zero, odd;
   logic             inflight_q, inflight_last_q;
   logic             fifo_empty;
   logic [OCC_W-1:0] fifo_occ;
   logic [ENT_W-1:0] fifo_out;
   logic [OCC_W:0]   used;

   assign load = trig_valid && trig_ready;

   tr_addr_seq #(.ADDR_W(ADDR_W), .REM_W(REM_W)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .base     (trig_base),
      .total    ({trig_count, 1'b0}),
      .step     (issue),
      .addr     (mem_rd_addr),
      .rem_zero (rem_zero),
      .odd      (odd)
   );

   assign used = {1'b0, fifo_occ} + {{OCC_W{1'b0}}, inflight_q};

   generate
      if (ISSUE_MODE == ISSUE_LOOKAHEAD) begin : g_lookahead
         assign room = used < ((OCC_W+1)'(BUF_DEPTH) + {{OCC_W{1'b0}}, pop});
      end else begin : g_registered
         assign room = used < (OCC_W+1)'(BUF_DEPTH);
      end
   endgenerate

   assign issue     = !rem_zero && room;
   assign mem_rd_en = issue;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         inflight_q      <= 1'b0;
         inflight_last_q <= 1'b0;
      end else begin
         inflight_q      <= issue;
         inflight_last_q <= odd;
      end
   end

   tr_flit_fifo #(.W(ENT_W), .DEPTH(BUF_DEPTH)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (inflight_q),
      .wr_data ({inflight_last_q, mem_rd_data}),
      .rd_en   (pop),
      .rd_data (fifo_out),
      .empty   (fifo_empty),
      .occ     (fifo_occ)
   );

   assign bus_valid  = !fifo_empty;
   assign pop        = bus_valid && bus_ready;
   assign bus_flit   = fifo_out[FLIT_W-1:0];
   assign bus_last   = fifo_out[FLIT_W];
   assign busy       = !rem_zero || inflight_q || !fifo_empty;
   assign trig_ready = !busy;

   // Independent marker tracker used only by the checks
   logic exp_last_q;
   always_ff @(posedge clk) begin
      if (!rst_n)    exp_last_q <= 1'b0;
      else if (pop)  exp_last_q <= ~exp_last_q;
   end

   assert_marker_alt_R6: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> bus_last == exp_last_q);
   assert_bus_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && !bus_ready) |=> bus_valid && $stable(bus_flit) && $stable(bus_last));
   assert_busy_on_take_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (load && trig_count != '0) |=> busy);
   assert_zero_count_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (load && trig_count == '0) |=> !busy);
endmodule

// File: tb/tok_replay_tb.sv
`timescale 1ns/1ps
module tok_replay_tb;
   localparam int FLIT_W = 16;
   localparam int ADDR_W = 10;
   localparam int CNT_W  = 8;

   logic              clk = 1'b0;
   logic              rst_n;
   logic              trig_valid, trig_ready;
   logic [ADDR_W-1:0] trig_base;
   logic [CNT_W-1:0]  trig_count;
   logic              mem_rd_en;
   logic [ADDR_W-1:0] mem_rd_addr;
   logic [FLIT_W-1:0] mem_rd_data = '0;
   logic              bus_valid, bus_ready, bus_last, busy;
   logic [FLIT_W-1:0] bus_flit;

   always #5 clk = ~clk;

   tok_replay u_dut (
      .clk(clk), .rst_n(rst_n),
      .trig_valid(trig_valid), .trig_ready(trig_ready),
      .trig_base(trig_base), .trig_count(trig_count),
      .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
      .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_flit(bus_flit),
      .bus_last(bus_last), .busy(busy)
   );

   function automatic logic [FLIT_W-1:0] pat(input logic [ADDR_W-1:0] a);
      return (16'(a) * 16'd40503) ^ 16'h3C5A;
   endfunction

   // memory with one cycle of read latency
   always @(posedge clk) if (mem_rd_en) mem_rd_data <= pat(mem_rd_addr);

   int checks = 0;
   int errors = 0;
   logic [FLIT_W:0] exp_q[$];

   task automatic fail(input string req, input int act, input int exp);
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
   endtask

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) fail(req, act, exp);
   endtask

   // Cycle-by-cycle reference model
   always @(negedge clk) begin
      #1;
      if (rst_n === 1'b1) begin
         chk("R11 busy", int'(busy), int'(exp_q.size() != 0));
         chk("R2 trig_ready", int'(trig_ready), int'(!busy));
         if (bus_valid) begin
            if (exp_q.size() == 0) fail("R3 unexpected flit", int'(bus_flit), 0);
            else begin
               chk("R4/R6 flit", int'({bus_last, bus_flit}), int'(exp_q[0]));
               if (bus_ready) void'(exp_q.pop_front());
            end
         end
         if (trig_valid && trig_ready) begin
            for (int k = 0; k < 2 * int'(trig_count); k++)
               exp_q.push_back({1'(k % 2), pat(ADDR_W'(int'(trig_base) + k))});
         end
      end
   end

   task automatic trig(input int base, input int cnt);
      @(negedge clk);
      trig_valid = 1'b1;
      trig_base  = ADDR_W'(base);
      trig_count = CNT_W'(cnt);
      @(negedge clk);
      trig_valid = 1'b0;
   endtask

   task automatic wait_idle();
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         #2;
         if (!busy) break;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fail("watchdog", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int n;
      logic [FLIT_W-1:0] got[$];
      rst_n = 1'b0; trig_valid = 1'b0; trig_base = '0; trig_count = '0; bus_ready = 1'b0;
      repeat (3) @(negedge clk);
      #2;
      // R1 reset state
      chk("R1 busy", int'(busy), 0);
      chk("R1 bus_valid", int'(bus_valid), 0);
      chk("R1 trig_ready", int'(trig_ready), 1);
      chk("R1 mem_rd_en", int'(mem_rd_en), 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R9 latency and gapless streaming, R3 total
      bus_ready = 1'b1;
      trig(10, 3);
      #2; chk("R9 valid cycle1", int'(bus_valid), 0);
      @(negedge clk); #2; chk("R9 valid cycle2", int'(bus_valid), 0);
      @(negedge clk); #2; chk("R9 valid cycle3", int'(bus_valid), 1);
      n = 0;
      while (bus_valid && n < 100) begin
         n++;
         @(negedge clk); #2;
      end
      chk("R9 gapless run length", n, 6);
      chk("R3 idle after sequence", int'(busy), 0);

      // R7 backpressure with an irregular ready pattern
      trig(100, 5);
      for (int c = 0; c < 80; c++) begin
         @(negedge clk);
         bus_ready = ((c * 7) % 5) > 1;
      end
      bus_ready = 1'b1;
      wait_idle();
      chk("R3 queue drained", exp_q.size(), 0);

      // R2 trigger offered while busy is refused
      bus_ready = 1'b0;
      trig(200, 2);
      for (int c = 0; c < 5; c++) begin
         @(negedge clk);
         trig_valid = 1'b1; trig_base = ADDR_W'(300); trig_count = CNT_W'(4);
         #2; chk("R2 refused while busy", int'(trig_ready), 0);
      end
      @(negedge clk);
      trig_valid = 1'b0;
      bus_ready = 1'b1;
      wait_idle();
      for (int c = 0; c < 10; c++) begin
         @(negedge clk); #2;
         chk("R2 no extra flits", int'(bus_valid), 0);
      end

      // R5 address wrap
      trig(1022, 2);
      for (int c = 0; c < 30; c++) begin
         @(negedge clk); #2;
         if (bus_valid && bus_ready) got.push_back(bus_flit);
      end
      chk("R5 wrap count", got.size(), 4);
      if (got.size() == 4) begin
         chk("R5 flit at cell 1023", int'(got[1]), int'(pat(10'd1023)));
         chk("R5 flit at cell 0", int'(got[2]), int'(pat(10'd0)));
         chk("R5 flit at cell 1", int'(got[3]), int'(pat(10'd1)));
      end

      // R10 zero count
      trig(50, 0);
      for (int c = 0; c < 10; c++) begin
         #2;
         chk("R10 busy", int'(busy), 0);
         chk("R10 bus_valid", int'(bus_valid), 0);
         chk("R10 mem_rd_en", int'(mem_rd_en), 0);
         @(negedge clk);
      end

      // R3 / R8 longer sequence with alternating ready
      trig(400, 40);
      for (int c = 0; c < 300; c++) begin
         @(negedge clk);
         bus_ready = (c % 3) != 2;
      end
      bus_ready = 1'b1;
      wait_idle();
      chk("R3 long sequence drained", exp_q.size(), 0);
      chk("R8 idle with no read", int'(mem_rd_en), 0);

      repeat (3) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule